// File: doc/BRIEF.md
# DMA Channel Transfer Engine

This block is the datapath and sequencer of one direct-memory-access channel. It keeps a memory pointer, a second pointer that addresses either a peripheral data register or a second memory buffer, a remaining-element counter with its reload copy, and a set of mode bits. Each element is moved as one read from the source followed by one write of the same data to the destination. The transfer goes over a simple request/acknowledge memory-mapped bus. After each element the pointers step, the counter counts down, and two sticky events are recorded: the half-way point and completion. Each event can raise the interrupt line when its own enable bit is set.

Software programs the channel through a small register port. It loads the pointers and the element count while the channel is stopped, picks the direction (peripheral to memory, memory to peripheral, or memory to memory), the element size (byte or halfword), the pointer direction (up or down) and normal or circular operation, and then sets the enable bit. In the peripheral directions every element waits for a request pulse from the peripheral. Memory-to-memory runs back to back without requests. A normal run stops by itself with the counter at zero. A circular run restores the count and both pointers and keeps going.

Register map (3-bit address, register data is ADDR_W bits wide, reads are registered): 0 control, 1 count (read gives the remaining count), 2 memory pointer, 3 second pointer, 4 status, 5 reload copy of the count. Control bits: [0] enable, [1] circular, [2] count pointers down, [3] halfword elements, [5:4] direction (0 peripheral to memory, 1 memory to peripheral, 2 or 3 memory to memory), [6] half-way interrupt enable, [7] completion interrupt enable. Status bits: [0] half-way flag, [1] completion flag, [2] busy, [3] pending. Writing a 1 to status bit 0 or 1 clears that flag.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset the control, count, pointer and status registers read 0, and irq, busy, pending and bus_req are low.
- R2: While the channel is enabled or an element is in flight, writes to the count, pointer and mode fields are ignored. Control bits [7:6] and [0] stay writable.
- R3: Setting the enable bit is refused (the bit stays 0) while the count is 0 or an element is still in flight.
- R4: Each element is one bus read of the source and then one bus write of the read data to the destination. The source is the second pointer for direction 0 and the memory pointer otherwise. The destination is the other pointer. The request, address and write strobe are held until bus_ack.
- R5: The count drops by one when each element completes. In normal mode the element that brings it to 0 also clears the enable bit, and later requests move no data.
- R6: In circular mode the element that brings the count to 0 reloads the count from the reload copy and both pointers from the values last written, and the channel stays enabled.
- R7: The memory pointer steps by 1 for byte elements or by 2 for halfword elements, up when control bit [2] is 0 and down when it is 1. The second pointer stays fixed in directions 0 and 1 and takes the same step in memory-to-memory mode.
- R8: bus_size is 1 for halfword elements and 0 for bytes. In byte mode bus_wdata[15:8] is 0 whatever the upper read byte was.
- R9: The half-way flag sets when the remaining count becomes reload/2 (integer division). The completion flag sets when the count reaches 0. Both stay set until software writes 1 to their status bit, and clearing one leaves the other alone.
- R10: irq is high one cycle after (half-way flag AND bit [6]) OR (completion flag AND bit [7]) is true.
- R11: A one-cycle dreq pulse while enabled sets pending in the next cycle. The element then starts a cycle later, when busy rises and pending falls. dreq has no effect while the channel is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | ADDR_W | Register write data |
| cfg_we | input | 1 | Register write strobe |
| cfg_rdata | output | ADDR_W | Registered read data of cfg_addr |
| dreq | input | 1 | Peripheral request pulse |
| bus_req | output | 1 | Bus transfer request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_size | output | 1 | 1 = halfword, 0 = byte |
| bus_addr | output | ADDR_W | Bus byte address |
| bus_wdata | output | 16 | Bus write data |
| bus_rdata | input | 16 | Bus read data, valid with bus_ack on a read |
| bus_ack | input | 1 | Transfer accepted/completed |
| busy | output | 1 | Element in flight |
| pending | output | 1 | Request waiting to start |
| irq | output | 1 | Channel interrupt |

## Verification
Register reads come back one cycle after the address is presented, so the bench samples cfg_rdata on the falling edge that follows. The pending and busy edges after a dreq pulse fall one and two cycles after the pulse, and the bench checks them at exactly those falling edges. How long an element takes depends on the bus acknowledge, so the bench waits for busy to rise and fall and then reads the count, flags and irq, which are all due by then. It sweeps every direction, mode, step and size combination with counts from 1 to 7. Each logged bus write is compared with addresses and data computed from the programmed bases.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int DATA_W = 16;
  localparam int RA_W   = 3;

  localparam logic [RA_W-1:0] RA_CTRL = 3'd0;
  localparam logic [RA_W-1:0] RA_CNT  = 3'd1;
  localparam logic [RA_W-1:0] RA_MPTR = 3'd2;
  localparam logic [RA_W-1:0] RA_PPTR = 3'd3;
  localparam logic [RA_W-1:0] RA_STAT = 3'd4;
  localparam logic [RA_W-1:0] RA_RLD  = 3'd5;

  // control register image, bit 0 (en) is the LSB
  typedef struct packed {
    logic       tc_ie;
    logic       ht_ie;
    logic [1:0] dir;
    logic       half;
    logic       dec;
    logic       circ;
    logic       en;
  } ctrl_t;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_UPD} seq_st_e;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RA_W-1:0]   cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              cfg_we,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic              xfer_done,
  input  logic              busy,
  input  logic              pend,
  input  logic [1:0]        flags,
  output ctrl_t             ctrl,
  output logic [ADDR_W-1:0] mem_ptr,
  output logic [ADDR_W-1:0] per_ptr,
  output logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  rld,
  output logic              ht_evt,
  output logic              tc_evt,
  output logic [1:0]        clr_flags
);
  localparam int CPAD = ADDR_W - CNT_W;
  localparam int KPAD = ADDR_W - 8;
  localparam int SPAD = ADDR_W - 4;

  ctrl_t             ctrl_q;
  logic [CNT_W-1:0]  cnt_q, rld_q, cnt_dec;
  logic [ADDR_W-1:0] mbase_q, pbase_q, mptr_q, pptr_q;
  logic [ADDR_W-1:0] step, mptr_nxt, pptr_nxt;
  logic              idle_cfg, last;
  logic              wr_ctrl, wr_cnt, wr_mptr, wr_pptr, wr_stat;

  assign wr_ctrl  = cfg_we && (cfg_addr == RA_CTRL);
  assign wr_cnt   = cfg_we && (cfg_addr == RA_CNT);
  assign wr_mptr  = cfg_we && (cfg_addr == RA_MPTR);
  assign wr_pptr  = cfg_we && (cfg_addr == RA_PPTR);
  assign wr_stat  = cfg_we && (cfg_addr == RA_STAT);
  assign idle_cfg = !ctrl_q.en && !busy;

  assign cnt_dec  = cnt_q - 1'b1;
  assign last     = xfer_done && (cnt_dec == '0);
  assign step     = ctrl_q.half ? ADDR_W'(2) : ADDR_W'(1);
  assign mptr_nxt = ctrl_q.dec ? (mptr_q - step) : (mptr_q + step);
  assign pptr_nxt = !ctrl_q.dir[1] ? pptr_q :
                    (ctrl_q.dec ? (pptr_q - step) : (pptr_q + step));

  assign ht_evt    = xfer_done && (cnt_dec == (rld_q >> 1));
  assign tc_evt    = last;
  assign clr_flags = wr_stat ? cfg_wdata[1:0] : 2'b00;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      cnt_q   <= '0;
      rld_q   <= '0;
      mbase_q <= '0;
      pbase_q <= '0;
      mptr_q  <= '0;
      pptr_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.ht_ie <= cfg_wdata[6];
        ctrl_q.tc_ie <= cfg_wdata[7];
        if (!cfg_wdata[0])
          ctrl_q.en <= 1'b0;
        else if (!ctrl_q.en)
          ctrl_q.en <= idle_cfg && (cnt_q != '0);
        if (idle_cfg) begin
          ctrl_q.circ <= cfg_wdata[1];
          ctrl_q.dec  <= cfg_wdata[2];
          ctrl_q.half <= cfg_wdata[3];
          ctrl_q.dir  <= cfg_wdata[5:4];
        end
      end
      if (wr_cnt && idle_cfg) begin
        cnt_q <= cfg_wdata[CNT_W-1:0];
        rld_q <= cfg_wdata[CNT_W-1:0];
      end
      if (wr_mptr && idle_cfg) begin
        mbase_q <= cfg_wdata;
        mptr_q  <= cfg_wdata;
      end
      if (wr_pptr && idle_cfg) begin
        pbase_q <= cfg_wdata;
        pptr_q  <= cfg_wdata;
      end
      if (xfer_done) begin
        if (last && ctrl_q.circ) begin
          cnt_q  <= rld_q;
          mptr_q <= mbase_q;
          pptr_q <= pbase_q;
        end else begin
          cnt_q  <= cnt_dec;
          mptr_q <= mptr_nxt;
          pptr_q <= pptr_nxt;
          if (last) ctrl_q.en <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata <= '0;
    end else begin
      case (cfg_addr)
        RA_CTRL: cfg_rdata <= {{KPAD{1'b0}}, ctrl_q};
        RA_CNT:  cfg_rdata <= {{CPAD{1'b0}}, cnt_q};
        RA_MPTR: cfg_rdata <= mptr_q;
        RA_PPTR: cfg_rdata <= pptr_q;
        RA_STAT: cfg_rdata <= {{SPAD{1'b0}}, pend, busy, flags};
        RA_RLD:  cfg_rdata <= {{CPAD{1'b0}}, rld_q};
        default: cfg_rdata <= '0;
      endcase
    end
  end

  assign ctrl    = ctrl_q;
  assign cnt     = cnt_q;
  assign rld     = rld_q;
  assign mem_ptr = mptr_q;
  assign per_ptr = pptr_q;
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              auto_run,
  input  logic              half,
  input  logic              dreq,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] dst_addr,
  output logic              bus_req,
  output logic              bus_we,
  output logic              bus_size,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ack,
  output logic              xfer_done,
  output logic              busy,
  output logic              pend
);
  localparam int HB = DATA_W / 2;

  seq_st_e st;
  logic    pend_q, start;

  assign start     = (st == ST_IDLE) && en && (auto_run || pend_q);
  assign xfer_done = (st == ST_UPD);
  assign busy      = (st != ST_IDLE);
  assign pend      = pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      pend_q    <= 1'b0;
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_size  <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      pend_q <= en && (dreq || (pend_q && !start));
      case (st)
        ST_IDLE: if (start) begin
          st       <= ST_RD;
          bus_req  <= 1'b1;
          bus_we   <= 1'b0;
          bus_size <= half;
          bus_addr <= src_addr;
        end
        ST_RD: if (bus_ack) begin
          st        <= ST_WR;
          bus_we    <= 1'b1;
          bus_addr  <= dst_addr;
          bus_wdata <= bus_size ? bus_rdata : {{HB{1'b0}}, bus_rdata[HB-1:0]};
        end
        ST_WR: if (bus_ack) begin
          st      <= ST_UPD;
          bus_req <= 1'b0;
          bus_we  <= 1'b0;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_chan_flags.sv
module dma_chan_flags #(
  parameter int NFLAG = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NFLAG-1:0] set_evt,
  input  logic [NFLAG-1:0] clr,
  input  logic [NFLAG-1:0] ie,
  output logic [NFLAG-1:0] flags,
  output logic             irq
);
  logic [NFLAG-1:0] flag_q;

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) flag_q[i] <= 1'b0;
      else     flag_q[i] <= set_evt[i] || (flag_q[i] && !clr[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(flag_q & ie);
  end

  assign flags = flag_q;
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RA_W-1:0]   cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              cfg_we,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic              dreq,
  output logic              bus_req,
  output logic              bus_we,
  output logic              bus_size,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ack,
  output logic              busy,
  output logic              pending,
  output logic              irq
);
  ctrl_t             ctrl;
  logic [ADDR_W-1:0] mem_ptr, per_ptr, src_addr, dst_addr;
  logic [CNT_W-1:0]  cnt, rld;
  logic              xfer_done, ht_evt, tc_evt, mem_src;
  logic [1:0]        flags, clr_flags;

  assign mem_src  = (ctrl.dir != 2'd0);
  assign src_addr = mem_src ? mem_ptr : per_ptr;
  assign dst_addr = mem_src ? per_ptr : mem_ptr;

  dma_chan_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_we(cfg_we), .cfg_rdata(cfg_rdata),
    .xfer_done(xfer_done), .busy(busy), .pend(pending), .flags(flags),
    .ctrl(ctrl), .mem_ptr(mem_ptr), .per_ptr(per_ptr), .cnt(cnt), .rld(rld),
    .ht_evt(ht_evt), .tc_evt(tc_evt), .clr_flags(clr_flags)
  );

  dma_chan_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst(rst),
    .en(ctrl.en), .auto_run(ctrl.dir[1]), .half(ctrl.half), .dreq(dreq),
    .src_addr(src_addr), .dst_addr(dst_addr),
    .bus_req(bus_req), .bus_we(bus_we), .bus_size(bus_size), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .xfer_done(xfer_done), .busy(busy), .pend(pending)
  );

  dma_chan_flags #(.NFLAG(2)) u_flags (
    .clk(clk), .rst(rst),
    .set_evt({tc_evt, ht_evt}), .clr(clr_flags), .ie({ctrl.tc_ie, ctrl.ht_ie}),
    .flags(flags), .irq(irq)
  );
endmodule

// File: rtl/dma_chan_engine_chk.sv
module dma_chan_engine_chk
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_req,
  input logic              bus_ack,
  input logic              bus_we,
  input logic              bus_size,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              busy,
  input logic              irq,
  input logic              cfg_we,
  input logic [RA_W-1:0]   cfg_addr,
  input logic              en,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  rld,
  input logic              xfer_done,
  input logic [1:0]        flags,
  input logic [1:0]        clr
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we))); // R4
  AST_REQ_BUSY: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> busy); // R11
  AST_EN_CNT_NZ: assert property (@(posedge clk) disable iff (rst)
    en |-> (cnt != '0)); // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    ((cnt != $past(cnt)) && !$past(cfg_we && (cfg_addr == RA_CNT)))
      |-> ((cnt == CNT_W'($past(cnt) - 1'b1)) || (cnt == rld))); // R5
  AST_CNT_LOCK: assert property (@(posedge clk) disable iff (rst)
    (en && cfg_we && (cfg_addr == RA_CNT) && !xfer_done) |=> (cnt == $past(cnt))); // R2
  AST_BYTE_UPPER: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_we && !bus_size) |-> (bus_wdata[15:8] == 8'h00)); // R8
  AST_TC_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flags[1] && !clr[1]) |=> flags[1]); // R9
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    (flags == 2'b00) |=> !irq); // R10
endmodule

bind dma_chan_engine dma_chan_engine_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_ack(bus_ack), .bus_we(bus_we),
  .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .busy(busy),
  .irq(irq), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .en(ctrl.en), .cnt(cnt),
  .rld(rld), .xfer_done(xfer_done), .flags(flags), .clr(clr_flags)
);

// File: tb/dma_chan_engine_test.sv
`timescale 1ns/1ps
module dma_chan_engine_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_rdata;
  logic        dreq = 1'b0;
  logic        bus_req, bus_we, bus_size, busy, pending, irq;
  logic [15:0] bus_addr, bus_wdata;
  logic [15:0] bus_rdata = '0;
  logic        bus_ack = 1'b0;

  int checks = 0;
  int failures = 0;
  int wcnt = 0;
  logic [15:0] wlog_a [0:63];
  logic [15:0] wlog_d [0:63];

  always #5 clk = ~clk;

  dma_chan_engine uut (
    .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_we(cfg_we),
    .cfg_rdata(cfg_rdata), .dreq(dreq), .bus_req(bus_req), .bus_we(bus_we),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .busy(busy), .pending(pending), .irq(irq)
  );

  function automatic logic [7:0] bval(input int a);
    return 8'(((a & 255) * 37) + 11);
  endfunction

  // bus slave: one-cycle acknowledge, reads from a computed image, writes logged
  always @(posedge clk) begin
    if (rst) begin
      bus_ack <= 1'b0;
    end else if (bus_req && !bus_ack) begin
      bus_ack <= 1'b1;
      if (bus_we) begin
        wlog_a[wcnt % 64] <= bus_addr;
        wlog_d[wcnt % 64] <= bus_wdata;
        wcnt <= wcnt + 1;
      end else if (bus_size) begin
        bus_rdata <= {bval(int'(bus_addr) + 1), bval(int'(bus_addr))};
      end else begin
        bus_rdata <= {8'hEE, bval(int'(bus_addr))};
      end
    end else begin
      bus_ack <= 1'b0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input int a, input int d);
    @(negedge clk);
    cfg_addr = 3'(a); cfg_wdata = 16'(d); cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input int a, output int d);
    @(negedge clk);
    cfg_addr = 3'(a);
    @(negedge clk);
    d = int'(cfg_rdata);
  endtask

  task automatic pulse_req();
    @(negedge clk);
    dreq = 1'b1;
    @(negedge clk);
    dreq = 1'b0;
  endtask

  task automatic wait_element();
    while (!busy) @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic run_case(input int dir, input int circ, input int dec, input int half,
                          input int n, input int htie, input int tcie);
    int s, mbase, pbase, total, w0, ctrlv, v, eht, etc, rem, m2m;
    s = half ? 2 : 1;
    m2m = (dir == 2) ? 1 : 0;
    mbase = dec ? 'h7E : 'h40;
    pbase = m2m ? (dec ? 'hFE : 'hC0) : 'hB0;
    total = circ ? 2 * n : n;
    cfg_write(0, 0);
    while (busy) @(negedge clk);
    cfg_write(4, 3);
    cfg_write(2, mbase);
    cfg_write(3, pbase);
    cfg_write(1, n);
    ctrlv = (tcie << 7) | (htie << 6) | (dir << 4) | (half << 3) | (dec << 2) | (circ << 1) | 1;
    w0 = wcnt;
    eht = 0; etc = 0;
    cfg_write(0, ctrlv);
    if (m2m) begin
      while (wcnt - w0 < total) @(negedge clk);
      if (circ) cfg_write(0, ctrlv & 'hFE);
      while (busy) @(negedge clk);
      cfg_read(4, v);
      chk("R9 m2m flags", v & 3, 3);
    end else begin
      for (int k = 0; k < total; k++) begin
        pulse_req();
        wait_element();
        rem = n - ((k % n) + 1);
        if (rem == n / 2) eht = 1;
        if (rem == 0) etc = 1;
        cfg_read(1, v);
        chk((circ && rem == 0) ? "R6 count reload" : "R5 count step", v,
            (circ && rem == 0) ? n : rem);
        cfg_read(4, v);
        chk("R9 flags", v & 3, (etc << 1) | eht);
        chk("R10 irq", int'(irq), (eht & htie) | (etc & tcie));
      end
      cfg_read(2, v);
      if (circ) chk("R6 pointer reload", v, mbase);
      else      chk("R7 final pointer", v, dec ? mbase - n * s : mbase + n * s);
      if (!circ) begin
        cfg_read(0, v);
        chk("R5 enable cleared", v & 1, 0);
        v = wcnt;
        pulse_req();
        repeat (12) @(negedge clk);
        chk("R5 no move after end", wcnt, v);
      end
    end
    for (int i = 0; i < total; i++) begin
      int j, ma, pa, src, dst, dat;
      j = i % n;
      ma = dec ? mbase - j * s : mbase + j * s;
      pa = m2m ? (dec ? pbase - j * s : pbase + j * s) : pbase;
      src = (dir == 0) ? pa : ma;
      dst = (dir == 0) ? ma : pa;
      dat = half ? {bval(src + 1), bval(src)} : {8'h00, bval(src)};
      chk("R4 R7 write address", int'(wlog_a[(w0 + i) % 64]), dst);
      chk("R4 R8 write data", int'(wlog_d[(w0 + i) % 64]), dat);
    end
    cfg_write(4, 1);
    cfg_read(4, v);
    chk("R9 clear half flag only", v & 3, 2);
    cfg_write(4, 2);
    cfg_read(4, v);
    chk("R9 clear completion flag", v & 3, 0);
    @(negedge clk);
    chk("R10 irq after clear", int'(irq), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int v, w;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cfg_read(0, v); chk("R1 ctrl reset", v, 0);
    cfg_read(1, v); chk("R1 count reset", v, 0);
    cfg_read(2, v); chk("R1 pointer reset", v, 0);
    cfg_read(4, v); chk("R1 status reset", v, 0);
    chk("R1 outputs idle", int'({irq, busy, pending, bus_req}), 0);

    cfg_write(0, 1);
    cfg_read(0, v); chk("R3 enable refused at zero count", v & 1, 0);

    w = wcnt;
    pulse_req();
    chk("R11 pending ignored when disabled", int'(pending), 0);
    repeat (10) @(negedge clk);
    chk("R11 no move when disabled", wcnt, w);

    cfg_write(2, 'h40);
    cfg_write(3, 'hB0);
    cfg_write(1, 4);
    cfg_write(0, 1);
    cfg_write(1, 9);
    cfg_write(2, 'h10);
    cfg_read(1, v); chk("R2 count locked", v, 4);
    cfg_read(2, v); chk("R2 pointer locked", v, 'h40);

    @(negedge clk);
    dreq = 1'b1;
    @(negedge clk);
    dreq = 1'b0;
    chk("R11 pending set", int'({pending, busy}), 2);
    @(negedge clk);
    chk("R11 element started", int'({pending, busy}), 1);
    while (busy) @(negedge clk);
    cfg_read(1, v); chk("R5 first decrement", v, 3);
    cfg_read(2, v); chk("R7 byte step up", v, 'h41);
    chk("R4 R8 first write", int'(wlog_d[w % 64]), {8'h00, bval('hB0)});
    cfg_write(0, 0);

    for (int idx = 0; idx < 24; idx++)
      run_case(idx % 3, (idx / 3) % 2, (idx / 6) % 2, (idx / 12) % 2,
               1 + ((idx * 5) % 7), idx % 2, (idx / 2) % 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule